// File: doc/BRIEF.md
# Mixed Direct/Indexed Pixel Selector

This block forms the colour of every pixel of a frame buffer held in three planes. An 8-bit index plane holds a palette index per pixel. A 32-bit direct plane holds a true-colour word per pixel. A 32-bit control plane holds one mode word per pixel. For each pixel the block reads all three planes at once and inspects the mode byte of the control word. It then forwards either the low 24 bits of the direct word or the palette entry addressed by the index byte.

A frame starts with a one-cycle `start` pulse. The active width and height are sampled from input ports at that pulse. Pixels are scanned in raster order over a fixed line pitch of 1024 pixels, whatever the active width, so columns beyond the active width are never read. The three plane memories and the palette are outside the block. Each is a synchronous read port: data appears the cycle after its read enable and holds until the next read. The result leaves as a 24-bit RGB stream with a valid/ready handshake and end-of-line and end-of-frame markers. Back-pressure freezes the whole pipeline, including the plane reads.

Top module: `pix_mix_sel`

## Requirements
- R1: While reset is held and after its release, out_valid, frame_busy, plane_rd_en and pal_rd_en are all low until a frame is started.
- R2: When bits [31:24] of a pixel's control word equal 8'h03, the pixel's out_pix equals bits [23:0] of its direct word. Bits [31:24] of the direct word and bits [23:0] of the control word have no effect.
- R3: For any other control byte, pal_addr carries the pixel's index byte and out_pix equals the palette data returned for it, packed red [23:16], green [15:8], blue [7:0].
- R4: Pixel (x, y) is read at idx_addr = y*1024 + x for any active width, with wide_addr = 4*idx_addr as the byte address of its control and direct words.
- R5: A frame delivers each pixel exactly once, x fastest then y. out_eol marks the last pixel of each line, and out_eof marks only the last pixel of the frame.
- R6: While out_valid is high and out_ready low, out_valid stays high and out_pix, out_eol and out_eof stay unchanged. No pixel is dropped or repeated.
- R7: With out_ready held high, the first pixel is valid after the third rising edge following the edge that samples start, and the pixels follow one per clock with no gap.
- R8: start is sampled only while frame_busy is low. A width above 1024 is taken as 1024 and a height above 768 as 768. A start with a zero width or height is ignored. No plane read is issued while frame_busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a frame |
| act_width | input | 12 | Active pixels per line, sampled at start |
| act_height | input | 11 | Active lines per frame, sampled at start |
| frame_busy | output | 1 | A frame scan is in progress |
| plane_rd_en | output | 1 | Read strobe for the three planes |
| idx_addr | output | 20 | Pixel address in the index plane |
| wide_addr | output | 22 | Byte address in the control and direct planes |
| idx_data | input | 8 | Index plane byte, one cycle after the read |
| ctrl_data | input | 32 | Control word, first memory byte in [31:24] |
| direct_data | input | 32 | Direct colour word, first memory byte in [31:24] |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_addr | output | 8 | Palette index |
| pal_data | input | 24 | Palette colour, one cycle after the read |
| out_valid | output | 1 | out_pix holds a pixel |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_pix | output | 24 | RGB pixel |
| out_eol | output | 1 | Last pixel of a line |
| out_eof | output | 1 | Last pixel of the frame |

## Verification
On every cycle the assertions check the stall hold of the output, the absence of plane reads outside a frame, and the address step of one between reads on a line. They also check the return to column 0 after each line end and that an end-of-frame marker always carries an end-of-line marker. The colour selection and the palette packing can only be shown by the bench scenarios, which compare each delivered pixel with a model of plane contents computed from the address. The same holds for the clamping of width and height, the refusal of a start during a frame or with zero size, the start-up latency and the gap-free throughput.

// File: rtl/pms_pkg.sv
package pms_pkg;

  localparam int COL_W = 24;

  typedef enum logic { PMS_PALETTE = 1'b0, PMS_DIRECT = 1'b1 } pms_mode_t;

  typedef struct packed {
    logic eol;
    logic eof;
  } pms_mark_t;

  // Mode byte is the first byte in memory, which sits in [31:24].
  function automatic pms_mode_t pms_classify(input logic [31:0] ctrl_word,
                                             input logic [7:0]  direct_code);
    return (ctrl_word[31:24] == direct_code) ? PMS_DIRECT : PMS_PALETTE;
  endfunction

endpackage

// File: rtl/pms_scan.sv
module pms_scan import pms_pkg::*; #(
  parameter int PITCH_LOG2 = 10,
  parameter int MAX_W      = 1024,
  parameter int MAX_H      = 768,
  parameter int WW         = 12,
  parameter int HW         = 11,
  localparam int YCW       = $clog2(MAX_H),
  localparam int XLW       = PITCH_LOG2 + 1,
  localparam int PA_W      = PITCH_LOG2 + YCW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            start,
  input  logic [WW-1:0]   act_width,
  input  logic [HW-1:0]   act_height,
  output logic            busy,
  output logic            rd_en,
  output logic [PA_W-1:0] pix_addr,
  output pms_mark_t       mark
);

  localparam logic [XLW-1:0] XONE = 1;
  localparam logic [HW-1:0]  HONE = 1;

  logic [PITCH_LOG2-1:0] x_q;
  logic [YCW-1:0]        y_q;
  logic [XLW-1:0]        wlim_q;
  logic [HW-1:0]         hlim_q;
  logic [WW-1:0]         w_clamp;
  logic [HW-1:0]         h_clamp;
  logic                  last_x, last_y;

  // Linear address over the fixed pitch.
  function automatic logic [PA_W-1:0] lin_addr(input logic [YCW-1:0] yy,
                                               input logic [PITCH_LOG2-1:0] xx);
    return {yy, xx};
  endfunction

  always_comb begin
    w_clamp = (act_width  > WW'(MAX_W)) ? WW'(MAX_W) : act_width;
    h_clamp = (act_height > HW'(MAX_H)) ? HW'(MAX_H) : act_height;
  end

  assign last_x   = ({1'b0, x_q} == (wlim_q - XONE));
  assign last_y   = (HW'(y_q) == (hlim_q - HONE));
  assign rd_en    = busy & adv;
  assign pix_addr = lin_addr(y_q, x_q);
  assign mark     = '{eol: last_x, eof: last_x & last_y};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
      wlim_q <= '0;
      hlim_q <= '0;
    end else if (!busy) begin
      if (start && (w_clamp != '0) && (h_clamp != '0)) begin
        busy   <= 1'b1;
        x_q    <= '0;
        y_q    <= '0;
        wlim_q <= XLW'(w_clamp);
        hlim_q <= h_clamp;
      end
    end else if (adv) begin
      if (last_x) begin
        x_q <= '0;
        if (last_y) busy <= 1'b0;
        else        y_q  <= y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pms_decide.sv
module pms_decide import pms_pkg::*; #(
  parameter int         IDX_W       = 8,
  parameter logic [7:0] DIRECT_CODE = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             rd_issued,
  input  pms_mark_t        mark_in,
  input  logic [31:0]      ctrl_data,
  input  logic [31:0]      direct_data,
  input  logic [IDX_W-1:0] idx_data,
  output logic             pal_rd_en,
  output logic [IDX_W-1:0] pal_addr,
  output logic             v2,
  output logic             dir2,
  output logic [COL_W-1:0] col2,
  output pms_mark_t        mark2
);

  logic      v1;
  pms_mark_t mark1;
  pms_mode_t mode_now;

  assign mode_now  = pms_classify(ctrl_data, DIRECT_CODE);
  assign pal_rd_en = adv & v1 & (mode_now == PMS_PALETTE);
  assign pal_addr  = idx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      mark1 <= '0;
      v2    <= 1'b0;
      dir2  <= 1'b0;
      col2  <= '0;
      mark2 <= '0;
    end else if (adv) begin
      v1    <= rd_issued;
      mark1 <= mark_in;
      v2    <= v1;
      dir2  <= (mode_now == PMS_DIRECT);
      col2  <= direct_data[COL_W-1:0];
      mark2 <= mark1;
    end
  end

endmodule

// File: rtl/pms_emit.sv
module pms_emit import pms_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             v2,
  input  logic             dir2,
  input  logic [COL_W-1:0] col2,
  input  pms_mark_t        mark2,
  input  logic [COL_W-1:0] pal_data,
  output logic             out_valid,
  output logic [COL_W-1:0] out_pix,
  output logic             out_eol,
  output logic             out_eof
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_eol   <= 1'b0;
      out_eof   <= 1'b0;
    end else if (adv) begin
      out_valid <= v2;
      if (v2) begin
        out_pix <= dir2 ? col2 : pal_data;
        out_eol <= mark2.eol;
        out_eof <= mark2.eof;
      end
    end
  end

endmodule

// File: rtl/pix_mix_sel.sv
module pix_mix_sel import pms_pkg::*; #(
  parameter int         PITCH_LOG2  = 10,
  parameter int         MAX_W       = 1024,
  parameter int         MAX_H       = 768,
  parameter int         WW          = 12,
  parameter int         HW          = 11,
  parameter int         IDX_W       = 8,
  parameter logic [7:0] DIRECT_CODE = 8'h03,
  localparam int        YCW         = $clog2(MAX_H),
  localparam int        PA_W        = PITCH_LOG2 + YCW,
  localparam int        WA_W        = PA_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WW-1:0]    act_width,
  input  logic [HW-1:0]    act_height,
  output logic             frame_busy,
  output logic             plane_rd_en,
  output logic [PA_W-1:0]  idx_addr,
  output logic [WA_W-1:0]  wide_addr,
  input  logic [IDX_W-1:0] idx_data,
  input  logic [31:0]      ctrl_data,
  input  logic [31:0]      direct_data,
  output logic             pal_rd_en,
  output logic [IDX_W-1:0] pal_addr,
  input  logic [COL_W-1:0] pal_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [COL_W-1:0] out_pix,
  output logic             out_eol,
  output logic             out_eof
);

  // Named internal events, visible to the bound checker.
  logic             adv;
  logic             rd_eol;
  pms_mark_t        scan_mark;
  logic             s2_valid;
  logic             s2_direct;
  logic [COL_W-1:0] s2_colour;
  pms_mark_t        s2_mark;

  assign adv       = ~out_valid | out_ready;
  assign rd_eol    = scan_mark.eol;
  assign wide_addr = {idx_addr, 2'b00};

  pms_scan #(
    .PITCH_LOG2(PITCH_LOG2), .MAX_W(MAX_W), .MAX_H(MAX_H), .WW(WW), .HW(HW)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .adv(adv), .start(start),
    .act_width(act_width), .act_height(act_height),
    .busy(frame_busy), .rd_en(plane_rd_en), .pix_addr(idx_addr), .mark(scan_mark)
  );

  pms_decide #(.IDX_W(IDX_W), .DIRECT_CODE(DIRECT_CODE)) u_decide (
    .clk(clk), .rst_n(rst_n), .adv(adv), .rd_issued(plane_rd_en), .mark_in(scan_mark),
    .ctrl_data(ctrl_data), .direct_data(direct_data), .idx_data(idx_data),
    .pal_rd_en(pal_rd_en), .pal_addr(pal_addr),
    .v2(s2_valid), .dir2(s2_direct), .col2(s2_colour), .mark2(s2_mark)
  );

  pms_emit u_emit (
    .clk(clk), .rst_n(rst_n), .adv(adv), .v2(s2_valid), .dir2(s2_direct),
    .col2(s2_colour), .mark2(s2_mark), .pal_data(pal_data),
    .out_valid(out_valid), .out_pix(out_pix), .out_eol(out_eol), .out_eof(out_eof)
  );

endmodule

// File: rtl/pms_chk.sv
module pms_chk #(
  parameter int PA_W       = 20,
  parameter int PITCH_LOG2 = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            out_valid,
  input logic            out_ready,
  input logic [23:0]     out_pix,
  input logic            out_eol,
  input logic            out_eof,
  input logic            plane_rd_en,
  input logic [PA_W-1:0] idx_addr,
  input logic            rd_eol,
  input logic            frame_busy
);

  localparam logic [PA_W-1:0] AONE = 1;

  logic [PA_W-1:0] prev_addr;
  logic            prev_mid;
  logic            prev_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_mid  <= 1'b0;
      prev_end  <= 1'b0;
    end else if (plane_rd_en) begin
      prev_addr <= idx_addr;
      prev_mid  <= !rd_eol;
      prev_end  <= rd_eol;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_eol) && $stable(out_eof));

  // R8
  idle_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_busy |-> !plane_rd_en);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plane_rd_en && prev_mid |-> idx_addr == prev_addr + AONE);

  // R4
  line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plane_rd_en && prev_end |-> idx_addr[PITCH_LOG2-1:0] == '0);

  // R5
  eof_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eof |-> out_eol);

endmodule

bind pix_mix_sel pms_chk #(.PA_W(PA_W), .PITCH_LOG2(PITCH_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_pix(out_pix), .out_eol(out_eol), .out_eof(out_eof),
  .plane_rd_en(plane_rd_en), .idx_addr(idx_addr), .rd_eol(rd_eol),
  .frame_busy(frame_busy)
);

// File: tb/pix_mix_sel_bench.sv
`timescale 1ns/1ps
module pix_mix_sel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] act_width = '0;
  logic [10:0] act_height = '0;
  logic        frame_busy, plane_rd_en, pal_rd_en;
  logic [19:0] idx_addr;
  logic [21:0] wide_addr;
  logic [7:0]  idx_data = '0;
  logic [31:0] ctrl_data = '0, direct_data = '0;
  logic [7:0]  pal_addr;
  logic [23:0] pal_data = '0;
  logic        out_valid, out_eol, out_eof;
  logic        out_ready = 1'b0;
  logic [23:0] out_pix;

  int n_cmp = 0;
  int n_bad = 0;
  int seed  = 0;
  logic [26:0] expq[$];

  always #2 clk = ~clk;

  pix_mix_sel u_pix_mix_sel (
    .clk(clk), .rst_n(rst_n), .start(start), .act_width(act_width), .act_height(act_height),
    .frame_busy(frame_busy), .plane_rd_en(plane_rd_en), .idx_addr(idx_addr), .wide_addr(wide_addr),
    .idx_data(idx_data), .ctrl_data(ctrl_data), .direct_data(direct_data),
    .pal_rd_en(pal_rd_en), .pal_addr(pal_addr), .pal_data(pal_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .out_eol(out_eol), .out_eof(out_eof)
  );

  // Plane contents as functions of the address.
  function automatic logic [31:0] f_ctrl(input int a);
    logic [31:0] h;
    logic [7:0]  code;
    h = 32'(a) * 32'd1103515245 + 32'(seed) * 32'd12345;
    case ((a * 3 + seed) % 6)
      0, 1, 2: code = 8'h03;
      3:       code = 8'h00;
      4:       code = 8'h02;
      default: code = 8'h83;
    endcase
    return {code, h[23:0]};
  endfunction

  function automatic logic [31:0] f_dir(input int a);
    logic [31:0] h;
    h = (32'(a) * 32'd40503 + 32'(seed) * 32'd977) ^ (32'(a) << 9);
    return {h[31:24] | 8'h80, h[23:0]};
  endfunction

  function automatic logic [7:0] f_idx(input int a);
    return 8'(a * 13 + seed);
  endfunction

  function automatic logic [23:0] f_pal(input logic [7:0] i);
    return {i ^ 8'h5A, ~i, i + 8'(seed)};
  endfunction

  always @(posedge clk) begin
    if (plane_rd_en) begin
      idx_data    <= f_idx(int'(idx_addr));
      ctrl_data   <= f_ctrl(int'(wide_addr >> 2));
      direct_data <= f_dir(int'(wide_addr >> 2));
    end
    if (pal_rd_en) pal_data <= f_pal(pal_addr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build_exp(input int w, input int h);
    int wc, hc;
    wc = (w > 1024) ? 1024 : w;
    hc = (h > 768) ? 768 : h;
    expq.delete();
    for (int y = 0; y < hc; y++)
      for (int x = 0; x < wc; x++) begin
        int a;
        logic [31:0] c;
        logic dir;
        logic [23:0] p;
        a = y * 1024 + x;
        c = f_ctrl(a);
        dir = (c[31:24] == 8'h03);
        p = dir ? f_dir(a)[23:0] : f_pal(f_idx(a));
        expq.push_back({dir, (x == wc-1) && (y == hc-1), x == wc-1, p});
      end
  endtask

  // rmode 0: ready always high, 1: stall pattern. again: second start mid-frame.
  task automatic run_frame(input int w, input int h, input int rmode, input int sd, input bit again);
    int cyc, first, gaps, tail;
    bit prev_stall;
    logic [23:0] prev_pix;
    seed = sd;
    build_exp(w, h);
    @(negedge clk);
    start = 1'b1; act_width = 12'(w); act_height = 11'(h); out_ready = 1'b1;
    first = -1; gaps = 0; tail = 0; prev_stall = 1'b0; prev_pix = '0; cyc = 0;
    while (tail < 12 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start = again && (cyc == 6);
      if (again && cyc == 6) begin act_width = 12'd3; act_height = 11'd1; end
      out_ready = (rmode == 0) ? 1'b1 : (((cyc * 5 + sd) % 7) >= 3);
      #1;
      if (plane_rd_en) chk(wide_addr == {idx_addr, 2'b00}, "R4 wide address", 32'(wide_addr), {10'd0, idx_addr, 2'b00});
      if (prev_stall) begin
        chk(out_valid, "R6 valid dropped under stall", 32'(out_valid), 1);
        chk(out_pix == prev_pix, "R6 pixel changed under stall", 32'(out_pix), 32'(prev_pix));
      end
      if (out_valid && first < 0) first = cyc;
      if (rmode == 0 && first >= 0 && expq.size() > 0 && !out_valid) gaps++;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R8/R5 extra pixel", 32'(out_pix), 0);
        else begin
          logic [26:0] e;
          e = expq.pop_front();
          chk(out_pix == e[23:0], e[26] ? "R2 direct colour" : "R3 palette colour", 32'(out_pix), 32'(e[23:0]));
          chk({out_eof, out_eol} == e[25:24], "R5 markers", 32'({out_eof, out_eol}), 32'(e[25:24]));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_pix = out_pix;
      if (expq.size() == 0) tail++;
    end
    chk(expq.size() == 0, "R5 pixels missing", 32'(expq.size()), 0);
    if (rmode == 0) begin
      chk(first == 4, "R7 first pixel latency", 32'(first), 4);
      chk(gaps == 0, "R7 gaps with ready high", 32'(gaps), 0);
    end
    chk(!frame_busy, "R8 busy after frame", 32'(frame_busy), 0);
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!out_valid && !frame_busy && !plane_rd_en && !pal_rd_en, "R1 during reset",
        {28'd0, out_valid, frame_busy, plane_rd_en, pal_rd_en}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !frame_busy && !plane_rd_en && !pal_rd_en, "R1 after reset",
        {28'd0, out_valid, frame_busy, plane_rd_en, pal_rd_en}, 0);

    run_frame(16, 3, 0, 1, 1'b0);    // R2 R3 R5 R7
    run_frame(37, 5, 1, 2, 1'b0);    // R6 under stalls
    run_frame(1, 1000, 0, 3, 1'b0);  // R8 height clamp to 768
    run_frame(2000, 2, 1, 4, 1'b0);  // R8 width clamp, R4 full pitch
    run_frame(5, 4, 1, 5, 1'b1);     // R8 start during frame ignored
    run_frame(1, 1, 0, 6, 1'b0);     // R5 single pixel eol+eof

    // R8 zero width start ignored
    begin
      bit any;
      any = 1'b0;
      @(negedge clk);
      start = 1'b1; act_width = 12'd0; act_height = 11'd5;
      @(negedge clk);
      start = 1'b0;
      repeat (15) begin
        @(negedge clk);
        if (frame_busy || out_valid || plane_rd_en) any = 1'b1;
      end
      chk(!any, "R8 zero width start", 32'(any), 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule